// File: doc/BRIEF.md
# Stop-Mode Supply Supervisor

This controller runs a small processor's low-power halt state. When the CPU asks to stop, the block halts it while all processor state is kept. The block can then switch off the supply-voltage monitor if software has chosen that. A wake-up event brings the CPU back. Wake-up events are an external interrupt line, an expiring wake timer, a filtered supply warning, or a supply drop to the reset level. The wake timer counts pulses of a slow 8 kHz tick, so each step is 125 µs. A 16-bit reload reaches about 8.19 s.

On every exit from the halt state the block passes through a short re-arm phase. In that phase the monitor is forced on and the supply flags are sampled before the CPU is released. A warning seen in that phase raises the power-fail interrupt flag. A reset-level drop seen in that phase puts the CPU into reset instead of releasing it. A drop below the power-on-reset level is never masked. The analog comparators, the slow oscillator and the CPU sit outside the block. They reach it as synchronous levels and single-cycle pulses.

Top module: `stop_pf_supervisor`

## Requirements
- R1: After synchronous reset, cpu_run=1, cpu_rst=0, mon_en=1 and pf_flag=0, and the monitor-disable bit holds 1.
- R2: A stop_req in the running state halts the CPU from the next cycle (cpu_run=0). While halted, mon_en equals the inverse of the monitor-disable bit.
- R3: While running, mon_en is 1 whatever the monitor-disable bit holds. A cycle with mon_dis_we=1 loads mon_dis_d into that bit.
- R4: While halted, any set bit of ext_irq starts the re-arm phase (mon_en=1, cpu_run=0). The CPU runs again only after REARM_CYC cycles in that phase. It never goes straight from halted to running.
- R5: With wake_en=1 and a nonzero wake_reload, the value is captured at halt entry. The re-arm phase starts at the edge of the wake_reload-th tick_8k pulse seen while halted. A reload of 0, or wake_en=0, gives no timer wake.
- R6: While halted with the disable bit at 1, below_warn and below_rst have no effect: no flag, no reset, and the CPU stays halted.
- R7: below_por puts the block into reset (cpu_rst=1, cpu_run=0) at the next edge from any state, including a halt with the monitor disabled. The block leaves reset for running in the first cycle in which below_por and below_rst are both 0.
- R8: A warning counts only once below_warn has been 1 for FILT_CYC consecutive cycles with mon_en=1. Shorter runs are ignored. A counted warning sets pf_flag while running. While halted with the monitor on, it also starts the re-arm phase.
- R9: below_rst with the monitor on puts the block into reset at the next edge. If a warning would count in the same cycle, the reset wins and pf_flag is not set.
- R10: In the last re-arm cycle, below_warn=1 sets pf_flag as the CPU resumes. below_rst=1 in any re-arm cycle sends the block to reset.
- R11: stop_req during the re-arm phase is ignored.
- R12: pf_flag stays 1 until a cycle with pf_flag_clr=1. A warning set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_8k | input | 1 | One-cycle pulse per slow-clock period (125 µs) |
| stop_req | input | 1 | CPU request to enter the halt state |
| ext_irq | input | N_IRQ | External interrupt requests, any bit wakes |
| wake_reload | input | TMR_W | Wake timer reload, in ticks; 0 disables |
| wake_en | input | 1 | Wake timer enable |
| mon_dis_we | input | 1 | Write strobe for the monitor-disable bit |
| mon_dis_d | input | 1 | Value written to the monitor-disable bit |
| below_warn | input | 1 | Supply below the warning level |
| below_rst | input | 1 | Supply below the reset level |
| below_por | input | 1 | Supply below the power-on-reset level |
| pf_flag_clr | input | 1 | Write-1-to-clear for the interrupt flag |
| cpu_run | output | 1 | 1 lets the CPU execute, 0 halts it |
| mon_en | output | 1 | Supply monitor enable |
| pf_flag | output | 1 | Power-fail interrupt flag |
| cpu_rst | output | 1 | CPU reset |

## Verification
Two cases are hardest to reach from the ports. One is the warning that arrives while the monitor is off and is then caught only by the re-arm sample. The other is a halt with the monitor on, where a filtered warning must wake the CPU and not reset it. The halted and re-arm states look alike on the outputs. The bench therefore tells them apart by time: it holds idle cycles after a short warning dip and sees the CPU stay halted, where a re-arm would have released it. For the re-arm sample, the stimulus holds below_warn across the whole halt with the disable bit set, wakes the CPU with an interrupt, and expects the flag on the cycle the CPU resumes.

// File: rtl/spf_pkg.sv
// Package: shared types for the stop-mode supply supervisor.
// Assumes: nothing beyond a two-bit state encoding.
package spf_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STOP  = 2'd1,
        ST_REARM = 2'd2,
        ST_RESET = 2'd3
    } spf_state_e;
endpackage

// File: rtl/spf_wake_timer.sv
// Module: spf_wake_timer
// Captures a reload value when the CPU enters the halt state and counts it
// down by one on each slow tick while halted. It gives a one-cycle expire
// pulse on the tick that uses up the count.
// Assumes: tick_i is a single-cycle synchronous pulse; load_i and run_i are
// never both 1.
module spf_wake_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [TMR_W-1:0] reload_i,
    input  logic             en_i,
    output logic             expire_o
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt_q;
    logic             armed_q;
    logic             step;

    // step: a tick that applies to a running, armed count
    assign step     = run_i && armed_q && tick_i;
    assign expire_o = step && (cnt_q == ONE);

    // counter: capture at halt entry, count down on ticks, disarm at expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= reload_i;
            armed_q <= en_i && (reload_i != '0);
        end else if (step) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_TMR_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (cnt_q != '0)); // R5
    AST_TMR_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !tick_i && !load_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/spf_warn_filter.sv
// Module: spf_warn_filter
// Qualifies the warning comparator. hit_o is 1 once the sense input has been
// 1 for FILT_CYC consecutive cycles with the monitor enabled. It stays 1
// while the condition holds.
// Assumes: FILT_CYC >= 1; sense_i is already synchronous to clk.
module spf_warn_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_i,
    input  logic en_i,
    output logic hit_o
);
    localparam int            CW   = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          live;

    assign live  = sense_i && en_i;
    assign hit_o = live && (cnt_q == LAST);

    // run length: count consecutive live cycles, saturate at LAST
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!live) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    AST_FILT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8

    generate
        if (FILT_CYC > 1) begin : g_multi
            AST_FILT_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> $past(live)); // R8
        end
    endgenerate
endmodule

// File: rtl/spf_ctrl.sv
// Module: spf_ctrl
// Power-state sequencer: run, halt, re-arm and reset. It also holds the
// monitor-disable bit and the sticky power-fail flag, and derives the monitor
// enable.
// Assumes: warn_hit_i comes from a filter gated by mon_en_o; supply flags
// are synchronous; REARM_CYC >= 1.
module spf_ctrl
    import spf_pkg::*;
#(
    parameter int N_IRQ     = 4,
    parameter int REARM_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic [N_IRQ-1:0] ext_irq,
    input  logic             tmr_expire_i,
    input  logic             warn_hit_i,
    input  logic             below_warn,
    input  logic             below_rst,
    input  logic             below_por,
    input  logic             mon_dis_we,
    input  logic             mon_dis_d,
    input  logic             flag_clr,
    output logic             mon_en_o,
    output logic             tmr_load_o,
    output logic             tmr_run_o,
    output logic             pf_flag_o,
    output logic             cpu_run_o,
    output logic             cpu_rst_o
);
    localparam int             RCW   = $clog2(REARM_CYC + 1);
    localparam logic [RCW-1:0] RLAST = RCW'(REARM_CYC - 1);

    spf_state_e     st_q, st_d;
    logic [RCW-1:0] rc_q;
    logic           dis_q;
    logic           flag_q;
    logic           warn_set;
    logic           rst_lvl;
    logic           wake_evt;

    // monitor is off only while halted with the disable bit set
    assign mon_en_o   = (st_q != ST_STOP) || !dis_q;
    assign rst_lvl    = below_rst && mon_en_o;
    assign wake_evt   = (|ext_irq) || tmr_expire_i;
    assign tmr_run_o  = (st_q == ST_STOP);
    assign cpu_run_o  = (st_q == ST_RUN);
    assign cpu_rst_o  = (st_q == ST_RESET);
    assign pf_flag_o  = flag_q;

    // next state: supply conditions first, then wake and stop requests
    always_comb begin
        st_d       = st_q;
        warn_set   = 1'b0;
        tmr_load_o = 1'b0;
        case (st_q)
            ST_RUN: begin
                if (rst_lvl) begin
                    st_d = ST_RESET;
                end else begin
                    warn_set = warn_hit_i;
                    if (stop_req) begin
                        st_d       = ST_STOP;
                        tmr_load_o = 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (rst_lvl) begin
                    st_d = ST_RESET;
                end else if (warn_hit_i) begin
                    warn_set = 1'b1;
                    st_d     = ST_REARM;
                end else if (wake_evt) begin
                    st_d = ST_REARM;
                end
            end
            ST_REARM: begin
                if (below_rst) begin
                    st_d = ST_RESET;
                end else if (rc_q == RLAST) begin
                    st_d     = ST_RUN;
                    warn_set = below_warn;
                end
            end
            default: begin
                if (!below_rst && !below_por) begin
                    st_d = ST_RUN;
                end
            end
        endcase
        if (below_por) begin
            st_d     = ST_RESET;
            warn_set = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    // re-arm dwell counter: counts cycles spent in the re-arm phase
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_REARM) begin
            rc_q <= '0;
        end else if (rc_q != RLAST) begin
            rc_q <= rc_q + RCW'(1);
        end
    end

    // monitor-disable bit: resets to 1, written by software strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (mon_dis_we) begin
            dis_q <= mon_dis_d;
        end
    end

    // power-fail flag: set beats write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (warn_set) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    AST_STOP_NOT_DIRECT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP) |=> (st_q != ST_RUN)); // R4
    AST_POR_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        below_por |=> cpu_rst_o); // R7
    AST_REARM_IGNORES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REARM) |=> (st_q != ST_STOP)); // R11
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q); // R12
    AST_DIS_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP && !mon_en_o && !below_por) |=> !cpu_rst_o); // R6
    AST_RESET_WINS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_lvl && !flag_q && st_q != ST_REARM) |=> !flag_q); // R9
endmodule

// File: rtl/stop_pf_supervisor.sv
// Module: stop_pf_supervisor (top)
// Stop-mode supply supervisor: wake timer, warning filter and power-state
// sequencer connected together.
// Assumes: all inputs synchronous to clk; tick_8k is one cycle wide.
module stop_pf_supervisor #(
    parameter int TMR_W     = 16,
    parameter int N_IRQ     = 4,
    parameter int FILT_CYC  = 4,
    parameter int REARM_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_8k,
    input  logic             stop_req,
    input  logic [N_IRQ-1:0] ext_irq,
    input  logic [TMR_W-1:0] wake_reload,
    input  logic             wake_en,
    input  logic             mon_dis_we,
    input  logic             mon_dis_d,
    input  logic             below_warn,
    input  logic             below_rst,
    input  logic             below_por,
    input  logic             pf_flag_clr,
    output logic             cpu_run,
    output logic             mon_en,
    output logic             pf_flag,
    output logic             cpu_rst
);
    logic tmr_load;
    logic tmr_run;
    logic tmr_expire;
    logic warn_hit;

    spf_wake_timer #(.TMR_W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .run_i    (tmr_run),
        .tick_i   (tick_8k),
        .reload_i (wake_reload),
        .en_i     (wake_en),
        .expire_o (tmr_expire)
    );

    spf_warn_filter #(.FILT_CYC(FILT_CYC)) i_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_i (below_warn),
        .en_i    (mon_en),
        .hit_o   (warn_hit)
    );

    spf_ctrl #(.N_IRQ(N_IRQ), .REARM_CYC(REARM_CYC)) i_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_req     (stop_req),
        .ext_irq      (ext_irq),
        .tmr_expire_i (tmr_expire),
        .warn_hit_i   (warn_hit),
        .below_warn   (below_warn),
        .below_rst    (below_rst),
        .below_por    (below_por),
        .mon_dis_we   (mon_dis_we),
        .mon_dis_d    (mon_dis_d),
        .flag_clr     (pf_flag_clr),
        .mon_en_o     (mon_en),
        .tmr_load_o   (tmr_load),
        .tmr_run_o    (tmr_run),
        .pf_flag_o    (pf_flag),
        .cpu_run_o    (cpu_run),
        .cpu_rst_o    (cpu_rst)
    );
endmodule

// File: tb/test_stop_pf_supervisor.sv
module test_stop_pf_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int TMR_W      = 16;
    localparam int N_IRQ      = 4;
    localparam int NVEC       = 23;

    // vector: {stop, irq, warn, brst, por, clr} inputs, then expected
    // {cpu_run, cpu_rst, pf_flag, mon_en} after the clock edge
    localparam logic [9:0] VEC [NVEC] = '{
        10'b000000_1001, // R1 idle running
        10'b100000_0000, // R2 halt, monitor off (disable bit 1)
        10'b001000_0000, // R6 warning ignored
        10'b000100_0000, // R6 reset level ignored
        10'b010000_0001, // R4 interrupt starts re-arm
        10'b100000_0001, // R11 stop ignored in re-arm
        10'b000000_1001, // R4 resumes after two cycles
        10'b001000_1001, // R8 warn 1
        10'b001000_1001, // R8 warn 2
        10'b001000_1001, // R8 warn 3
        10'b001000_1011, // R8 warn 4 sets flag
        10'b000000_1011, // R12 flag holds
        10'b000001_1001, // R12 clear
        10'b000100_0101, // R9 reset level while running
        10'b000000_1001, // R7 leaves reset
        10'b100000_0000, // R2 halt
        10'b000010_0101, // R7 por during disabled halt
        10'b000010_0101, // R7 held
        10'b000000_1001, // R7 released
        10'b001000_1001, // R8 short dip 1
        10'b001000_1001, // R8 short dip 2
        10'b001000_1001, // R8 short dip 3
        10'b000000_1001  // R8 short dip ignored
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_8k = 1'b0;
    logic             stop_req = 1'b0;
    logic [N_IRQ-1:0] ext_irq = '0;
    logic [TMR_W-1:0] wake_reload = '0;
    logic             wake_en = 1'b0;
    logic             mon_dis_we = 1'b0;
    logic             mon_dis_d = 1'b0;
    logic             below_warn = 1'b0;
    logic             below_rst = 1'b0;
    logic             below_por = 1'b0;
    logic             pf_flag_clr = 1'b0;
    logic             cpu_run, mon_en, pf_flag, cpu_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_pf_supervisor #(.TMR_W(TMR_W), .N_IRQ(N_IRQ)) i_stop_pf_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_8k(tick_8k), .stop_req(stop_req),
        .ext_irq(ext_irq), .wake_reload(wake_reload), .wake_en(wake_en),
        .mon_dis_we(mon_dis_we), .mon_dis_d(mon_dis_d),
        .below_warn(below_warn), .below_rst(below_rst), .below_por(below_por),
        .pf_flag_clr(pf_flag_clr), .cpu_run(cpu_run), .mon_en(mon_en),
        .pf_flag(pf_flag), .cpu_rst(cpu_rst)
    );

    task automatic check(string req, logic [3:0] exp);
        logic [3:0] got;
        got = {cpu_run, cpu_rst, pf_flag, mon_en};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {run,rst,flag,mon} actual %b expected %b", req, got, exp);
        end
    endtask

    // apply inputs away from the edge, take one edge, check 1 time unit later
    task automatic step(string req, logic [5:0] in, logic [3:0] exp,
                        logic tk = 1'b0, logic we = 1'b0, logic wd = 1'b0);
        {stop_req, ext_irq[2], below_warn, below_rst, below_por, pf_flag_clr} = in;
        tick_8k    = tk;
        mon_dis_we = we;
        mon_dis_d  = wd;
        @(posedge clk);
        #1;
        check(req, exp);
        {stop_req, ext_irq[2], below_warn, below_rst, below_por, pf_flag_clr} = '0;
        tick_8k    = 1'b0;
        mon_dis_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        do_reset();
        check("R1 reset state", 4'b1001);

        for (int i = 0; i < NVEC; i++) begin
            step($sformatf("table[%0d]", i), VEC[i][9:4], VEC[i][3:0]);
        end

        // R5: timer wake after three ticks
        wake_reload = 16'd3; wake_en = 1'b1;
        step("R5 halt", 6'b100000, 4'b0000);
        step("R5 tick 1", 6'b000000, 4'b0000, 1'b1);
        step("R5 idle", 6'b000000, 4'b0000);
        step("R5 tick 2", 6'b000000, 4'b0000, 1'b1);
        step("R5 tick 3 wakes", 6'b000000, 4'b0001, 1'b1);
        step("R5 re-arm", 6'b000000, 4'b0001);
        step("R5 resume", 6'b000000, 4'b1001);

        // R5: reload 0 and disabled timer give no wake
        wake_reload = 16'd0;
        step("R5 halt reload0", 6'b100000, 4'b0000);
        for (int i = 0; i < 4; i++) step("R5 reload0 no wake", 6'b000000, 4'b0000, 1'b1);
        step("R4 irq wake", 6'b010000, 4'b0001);
        step("R4 re-arm", 6'b000000, 4'b0001);
        step("R4 resume", 6'b000000, 4'b1001);
        wake_reload = 16'd1; wake_en = 1'b0;
        step("R5 halt disabled", 6'b100000, 4'b0000);
        for (int i = 0; i < 3; i++) step("R5 enable0 no wake", 6'b000000, 4'b0000, 1'b1);
        step("R4 irq wake", 6'b010000, 4'b0001);
        step("R4 re-arm", 6'b000000, 4'b0001);
        step("R4 resume", 6'b000000, 4'b1001);

        // R3, R2, R8: monitor kept on during halt; filtered warning wakes
        step("R3 write disable 0", 6'b000000, 4'b1001, 1'b0, 1'b1, 1'b0);
        step("R2 halt monitor on", 6'b100000, 4'b0001);
        for (int i = 0; i < 3; i++) step("R8 short dip in halt", 6'b001000, 4'b0001);
        step("R8 still halted", 6'b000000, 4'b0001);
        step("R8 still halted", 6'b000000, 4'b0001);
        step("R8 still halted", 6'b000000, 4'b0001);
        for (int i = 0; i < 3; i++) step("R8 warn in halt", 6'b001000, 4'b0001);
        step("R8 warn wakes with flag", 6'b001000, 4'b0011);
        step("R8 re-arm", 6'b000000, 4'b0011);
        step("R8 resume", 6'b000000, 4'b1011);
        step("R12 clear", 6'b000001, 4'b1001);

        // R9: reset level beats a warning counted in the same cycle
        step("R9 halt", 6'b100000, 4'b0001);
        for (int i = 0; i < 3; i++) step("R9 warn", 6'b001000, 4'b0001);
        step("R9 reset wins", 6'b001100, 4'b0101);
        step("R9 release", 6'b000000, 4'b1001);

        // R10: warning present only at re-arm is sampled
        step("R3 write disable 1", 6'b000000, 4'b1001, 1'b0, 1'b1, 1'b1);
        step("R10 halt", 6'b100000, 4'b0000);
        step("R10 warn masked", 6'b001000, 4'b0000);
        step("R10 irq with warn", 6'b011000, 4'b0001);
        step("R10 re-arm warn", 6'b001000, 4'b0001);
        step("R10 resume with flag", 6'b001000, 4'b1011);
        step("R12 flag holds", 6'b000000, 4'b1011);
        step("R12 clear", 6'b000001, 4'b1001);

        // R10: reset level inside re-arm
        step("R10 halt", 6'b100000, 4'b0000);
        step("R10 irq", 6'b010000, 4'b0001);
        step("R10 reset in re-arm", 6'b000100, 4'b0101);
        step("R7 release", 6'b000000, 4'b1001);

        // R12: set beats clear
        for (int i = 0; i < 3; i++) step("R12 warn", 6'b001000, 4'b1001);
        step("R12 set beats clear", 6'b001001, 4'b1011);
        step("R12 clear", 6'b000001, 4'b1001);

        // R1: disable bit returns to 1 on reset
        step("R3 write disable 0", 6'b000000, 4'b1001, 1'b0, 1'b1, 1'b0);
        do_reset();
        check("R1 reset state again", 4'b1001);
        step("R1 disable bit back to 1", 6'b100000, 4'b0000);
        step("R4 irq", 6'b010000, 4'b0001);
        step("R4 re-arm", 6'b000000, 4'b0001);
        step("R4 resume", 6'b000000, 4'b1001);

        done = 1'b1;
        report();
    end
endmodule